// File: doc/BRIEF.md
# Byte-wide 16-bit register access bridge

This block lets a narrow 8-bit data bus read and write one 16-bit register, typically a capture or counter-limit register, without tearing. A single shared holding byte carries the half of the word that is not on the bus at that moment.

A read of the low address returns the live low byte combinationally. In the same access, it freezes the live high byte into the holding byte. A later read of the high address returns that frozen byte, so the two halves belong to the same instant.

Writes run the other way. The high-address write parks its byte in the holding byte. The low-address write then commits both halves in one clock edge. A commit happens only while the `limit_mode` input says the register serves as the counter limit. A capture unit beside the bridge can also load the word through a valid/value pair.

Top module: `wide_reg_bridge`

## Requirements
- R1: With `rst` high at a clock edge, the word and the holding byte both become zero.
- R2: While `bus_rd` is high with `bus_hi` = 0 (the low address), `bus_rdata` equals the low byte of the current word in the same cycle. While `bus_rd` is low, `bus_rdata` is zero.
- R3: A low-address read loads the holding byte with the word's high byte as it stood during that read.
- R4: While `bus_rd` is high with `bus_hi` = 1 (the high address), `bus_rdata` equals the holding byte, not the live high byte of the word.
- R5: A high-address write loads the holding byte with `bus_wdata` in every mode, and leaves the word unchanged.
- R6: A low-address write with `limit_mode` = 1 sets the word to {holding byte, `bus_wdata`} at that edge.
- R7: A low-address write with `limit_mode` = 0 leaves the word unchanged.
- R8: A cycle with `cap_valid` = 1 and no committing write loads the word with `cap_value`.
- R9: A committing low-address write and a capture in the same cycle resolve in favour of the write. When `limit_mode` = 0 in that cycle, the capture value is stored.
- R10: A high-address write placed between a low-address read and a high-address read makes that high read return the written byte, because the holding byte is shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_hi | input | 1 | Byte address: 0 low, 1 high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| limit_mode | input | 1 | 1 when the register defines the counter limit |
| cap_valid | input | 1 | Capture load request |
| cap_value | input | 16 | Capture word |
| word_q | output | 16 | Current register word |

## Verification
The bench sweeps many distinct word values through write-then-read round trips and checks every read against a model built from the rules above. A design that returned the live high byte on a high read would tear words that change between the two reads. The bench therefore loads a capture between the two reads.

Mode gating is tried with both settings. A bridge that committed writes outside limit mode would show a changed word. The write/capture collision is driven in both modes, so a fixed priority order fails one of the two cases. The shared-byte corruption sequence is run explicitly, so a bridge with separate read and write holding bytes would return the stale read value.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    localparam int BYTE_W_DFLT = 8;
    localparam int LANES       = 2;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Decoded single-cycle bus intent
    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
        logic commit;   // low write that is allowed to land
    } strobe_t;

    function automatic strobe_t decode_req(logic rd, logic wr, lane_e lane, logic limit);
        strobe_t s;
        s.rd_lo  = rd && (lane == LANE_LO);
        s.rd_hi  = rd && (lane == LANE_HI);
        s.wr_lo  = wr && (lane == LANE_LO);
        s.wr_hi  = wr && (lane == LANE_HI);
        s.commit = s.wr_lo && limit;
        return s;
    endfunction

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
(
    input  logic    bus_hi,
    input  logic    bus_rd,
    input  logic    bus_wr,
    input  logic    limit_mode,
    output strobe_t strb
);
    always_comb begin
        strb = decode_req(bus_rd, bus_wr, lane_e'(bus_hi), limit_mode);
    end
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold
    import wrb_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DFLT
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] live_hi,
    output logic [BYTE_W-1:0] hold_q
);
    // Shared holding byte: write path parks data, read path freezes live high byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (strb.wr_hi) begin
            hold_q <= wdata;
        end else if (strb.rd_lo) begin
            hold_q <= live_hi;
        end
    end
endmodule

// File: rtl/wrb_store.sv
module wrb_store
    import wrb_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DFLT,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] hold_q,
    input  logic              cap_valid,
    input  logic [WORD_W-1:0] cap_value,
    output logic [WORD_W-1:0] word_q
);
    // Per-lane storage; a committing bus write outranks a capture load.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bus_byte;
        assign bus_byte = (g == 0) ? wdata : hold_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (strb.commit) begin
                word_q[g*BYTE_W +: BYTE_W] <= bus_byte;
            end else if (cap_valid) begin
                word_q[g*BYTE_W +: BYTE_W] <= cap_value[g*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DFLT,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_hi,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              limit_mode,
    input  logic              cap_valid,
    input  logic [WORD_W-1:0] cap_value,
    output logic [WORD_W-1:0] word_q
);
    strobe_t           strb;
    logic [BYTE_W-1:0] hold_q;

    wrb_decode u_dec (
        .bus_hi     (bus_hi),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .limit_mode (limit_mode),
        .strb       (strb)
    );

    wrb_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wdata   (bus_wdata),
        .live_hi (word_q[WORD_W-1 -: BYTE_W]),
        .hold_q  (hold_q)
    );

    wrb_store #(.BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .strb      (strb),
        .wdata     (bus_wdata),
        .hold_q    (hold_q),
        .cap_valid (cap_valid),
        .cap_value (cap_value),
        .word_q    (word_q)
    );

    always_comb begin
        if (strb.rd_lo)      bus_rdata = word_q[BYTE_W-1:0];
        else if (strb.rd_hi) bus_rdata = hold_q;
        else                 bus_rdata = '0;
    end
endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = BYTE_W * 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_hi,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              limit_mode,
    input logic              cap_valid,
    input logic [WORD_W-1:0] cap_value,
    input logic [WORD_W-1:0] word_q,
    input logic [BYTE_W-1:0] hold_q
);
    p_lo_read_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_hi) |-> bus_rdata == word_q[BYTE_W-1:0]);

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);

    p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_hi) |=> hold_q == $past(word_q[WORD_W-1 -: BYTE_W]));

    p_hi_read_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_hi && $past(bus_rd && !bus_hi))
            |-> bus_rdata == $past(word_q[WORD_W-1 -: BYTE_W]));

    p_park_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_hi && !cap_valid) |=> $stable(word_q) && hold_q == $past(bus_wdata));

    p_commit_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_hi && limit_mode)
            |=> word_q == {$past(hold_q), $past(bus_wdata)});

    p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_hi && !limit_mode && !cap_valid) |=> $stable(word_q));

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !(bus_wr && !bus_hi && limit_mode)) |=> word_q == $past(cap_value));

    p_corrupt_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_hi && $past(bus_wr && bus_hi)) |-> bus_rdata == $past(bus_wdata));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_hi     (bus_hi),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .limit_mode (limit_mode),
    .cap_valid  (cap_valid),
    .cap_value  (cap_value),
    .word_q     (word_q),
    .hold_q     (hold_q)
);

// File: tb/wide_reg_bridge_tb_top.sv
module wide_reg_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_hi = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        limit_mode = 1'b0;
    logic        cap_valid = 1'b0;
    logic [15:0] cap_value = '0;
    logic [15:0] word_q;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_word = '0;
    logic [7:0]  m_hold = '0;

    always #4 clk = ~clk;

    wide_reg_bridge dut_i (
        .clk(clk), .rst(rst), .bus_hi(bus_hi), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .limit_mode(limit_mode),
        .cap_valid(cap_valid), .cap_value(cap_value), .word_q(word_q)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle; the model follows the requirements and predicts rdata and the new word.
    task automatic op(input string tag, input logic rd, input logic wr, input logic hi,
                      input logic [7:0] wd, input logic mode, input logic cv,
                      input logic [15:0] cval);
        logic [7:0]  exp_rd;
        logic [7:0]  nh;
        logic [15:0] nw;
        bus_rd = rd; bus_wr = wr; bus_hi = hi; bus_wdata = wd;
        limit_mode = mode; cap_valid = cv; cap_value = cval;
        exp_rd = !rd ? 8'h00 : (hi ? m_hold : m_word[7:0]);
        nh = m_hold;
        if (wr && hi)        nh = wd;
        else if (rd && !hi)  nh = m_word[15:8];
        nw = m_word;
        if (wr && !hi && mode) nw = {m_hold, wd};
        else if (cv)           nw = cval;
        #2;
        check(tag, {8'h00, bus_rdata}, {8'h00, exp_rd});
        @(posedge clk);
        #2;
        m_word = nw; m_hold = nh;
        bus_rd = 0; bus_wr = 0; cap_valid = 0;
        check(tag, word_q, m_word);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] b_hi, b_lo;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: reset state observed through reads
        check("R1 word", word_q, 16'h0000);
        op("R1 lo read", 1, 0, 0, 8'h00, 0, 0, 16'h0);
        op("R1 hi read", 1, 0, 1, 8'h00, 0, 0, 16'h0);
        op("R2 idle rdata", 0, 0, 0, 8'h00, 0, 0, 16'h0);

        // R5 R6 R2 R3 R4: limit-mode write/read round trips over many patterns
        for (int i = 0; i < 256; i++) begin
            b_hi = 8'(i * 37 + 5);
            b_lo = 8'(i * 91 + 3);
            op("R5 hi write", 0, 1, 1, b_hi, 1, 0, 16'h0);
            op("R6 lo commit", 0, 1, 0, b_lo, 1, 0, 16'h0);
            check("R6 word", word_q, {b_hi, b_lo});
            op("R2 R3 lo read", 1, 0, 0, 8'h00, 1, 0, 16'h0);
            op("R4 hi read", 1, 0, 1, 8'h00, 1, 0, 16'h0);
        end

        // R7: writes outside limit mode are ignored
        for (int i = 0; i < 32; i++) begin
            op("R7 hi write", 0, 1, 1, 8'(i * 13), 0, 0, 16'h0);
            op("R7 lo write", 0, 1, 0, 8'(i * 29 + 1), 0, 0, 16'h0);
            check("R7 unchanged", word_q, m_word);
        end

        // R8 R4: capture between low and high read; high read keeps the frozen byte
        for (int i = 0; i < 32; i++) begin
            op("R8 capture", 0, 0, 0, 8'h00, 0, 1, 16'(i * 2477 + 17));
            op("R3 lo read", 1, 0, 0, 8'h00, 0, 0, 16'h0);
            op("R8 capture2", 0, 0, 0, 8'h00, 0, 1, 16'(i * 911 + 40000));
            op("R4 frozen hi", 1, 0, 1, 8'h00, 0, 0, 16'h0);
        end

        // R9: collision in both modes
        op("R9 park", 0, 1, 1, 8'hA5, 1, 0, 16'h0);
        op("R9 write wins", 0, 1, 0, 8'h3C, 1, 1, 16'h1234);
        check("R9 limit mode", word_q, 16'hA53C);
        op("R9 park2", 0, 1, 1, 8'h77, 0, 0, 16'h0);
        op("R9 capture wins", 0, 1, 0, 8'h99, 0, 1, 16'hBEEF);
        check("R9 other mode", word_q, 16'hBEEF);

        // R10: high write between low read and high read corrupts the read
        op("R10 lo read", 1, 0, 0, 8'h00, 0, 0, 16'h0);
        op("R10 hi write", 0, 1, 1, 8'h5A, 0, 0, 16'h0);
        op("R10 hi read", 1, 0, 1, 8'h00, 0, 0, 16'h0);
        check("R10 word kept", word_q, 16'hBEEF);

        // R1: reset mid-run clears word and holding byte
        rst = 1'b1;
        @(posedge clk);
        #2 rst = 1'b0;
        m_word = '0; m_hold = '0;
        check("R1 re-reset", word_q, 16'h0000);
        op("R1 hold cleared", 1, 0, 1, 8'h00, 0, 0, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule